// File: doc/BRIEF.md
# Serial Configuration Port with Register Readback

This block is the configuration port of a mixed-signal chip. A host drives a chip-select, a serial clock and a data line; the block gathers the bits into 24-bit words, each an 8-bit address followed by 16 data bits. It writes the data into a small file of 16-bit registers whose contents drive the rest of the chip in parallel. One chip-select low period may carry any number of whole words. Bits left over at the end of a period do not complete a word and are dropped.

The serial pins are sampled by a faster system clock through synchronizers, and edges of the serial clock are detected in that domain. Two control bits have special meaning. Bit 7 of register 0x00 is a software reset: writing it clears the whole file, and the bit never reads back as set. Bit 0 of register 0x01 turns on readout mode. In readout mode the addressed register is shifted out on a data-out line whose driver is enabled only in this mode, and every write is refused except a write to register 0x01, which is how the host leaves the mode.

Top module: `cfg_serial_port`

## Requirements
- R1: Bits are taken from `sdi` on rising `sclk` edges only while `cs_n` is low; `sclk` activity while `cs_n` is high changes no register.
- R2: A word is 24 bits sent MSB first: address bits [23:16], then data bits [15:0]. The addressed register takes the data after the 24th rising edge of the word.
- R3: Several complete words sent in one `cs_n` low period are each written in turn.
- R4: Bits after the last complete word of a `cs_n` low period are discarded, and the bit count restarts whenever `cs_n` goes high, so a word begun in one period never completes in the next.
- R5: A write to address 0x00 with data bit 7 set clears every register to zero, bit 7 included. A write to 0x00 with bit 7 clear stores the data like any other register.
- R6: While `rst_n` is low, every register is zero and `sdo_oe` is low.
- R7: In readout mode, the 16 bits of the addressed register are presented on `sdo` MSB first. Bit 15 is present from just after the word's 8th rising edge, so it is sampled on the 9th. Each later bit follows the next falling edge.
- R8: `sdo_oe` is high exactly while bit 0 of register 0x01 is set; `sdo` is low whenever `sdo_oe` is low.
- R9: While readout mode is on, writes to any address other than 0x01 are ignored, a software-reset write included. Once the mode is cleared, writes work again.
- R10: In readout mode, addressing register 0x01 returns all zeros.
- R11: Addresses at or above the register count (16 by default) are never written and read back as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial pins |
| rst_n | input | 1 | Asynchronous hardware reset, active low |
| cs_n | input | 1 | Chip-select, active low, frames the words |
| sclk | input | 1 | Serial clock from the host |
| sdi | input | 1 | Serial data from the host, sampled on rising `sclk` |
| sdo | output | 1 | Serial readback data |
| sdo_oe | output | 1 | Output enable for the `sdo` pad driver (high-impedance when low) |
| cfg_q | output | NUM_REGS*16 | All registers in parallel, register n at bits [16n+15:16n] |

## Verification
The properties assume the host keeps each high and low phase of `sclk` at least five system-clock cycles long. They also assume `sdi` changes only while `sclk` is low and `cs_n` moves only while `sclk` is low. Under these conditions every serial edge is resolved through the synchronizers before the next one, and a write or readback load finishes well inside one phase. The stimulus holds each `sclk` phase for eight system clocks, changes `sdi` at the start of the low phase, and raises or lowers `cs_n` half a serial period away from any `sclk` edge. That includes the aborted and over-long frames.

// File: rtl/cfg_serial_port.sv
module cfg_serial_port #(
  parameter int ADDR_W      = 8,
  parameter int DATA_W      = 16,
  parameter int NUM_REGS    = 16,
  parameter int SYNC_STAGES = 2,
  parameter int SRST_ADDR   = 0,
  parameter int SRST_BIT    = 7,
  parameter int RDOUT_ADDR  = 1,
  parameter int RDOUT_BIT   = 0
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cs_n,
  input  logic                       sclk,
  input  logic                       sdi,
  output logic                       sdo,
  output logic                       sdo_oe,
  output logic [NUM_REGS*DATA_W-1:0] cfg_q
);
  localparam int WORD_W = ADDR_W + DATA_W;
  localparam int CNT_W  = $clog2(WORD_W);
  localparam int IDX_W  = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;

  logic [SYNC_STAGES:0]   sclk_sy;
  logic [SYNC_STAGES-1:0] cs_sy;
  logic [SYNC_STAGES-1:0] sdi_sy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_sy <= '0;
      cs_sy   <= '1;
      sdi_sy  <= '0;
    end else begin
      sclk_sy <= {sclk_sy[SYNC_STAGES-1:0], sclk};
      cs_sy   <= {cs_sy[SYNC_STAGES-2:0], cs_n};
      sdi_sy  <= {sdi_sy[SYNC_STAGES-2:0], sdi};
    end
  end

  logic cs_on, rise, fall, bit_in;
  assign cs_on  = !cs_sy[SYNC_STAGES-1];
  assign rise   = cs_on &&  sclk_sy[SYNC_STAGES-1] && !sclk_sy[SYNC_STAGES];
  assign fall   = cs_on && !sclk_sy[SYNC_STAGES-1] &&  sclk_sy[SYNC_STAGES];
  assign bit_in = sdi_sy[SYNC_STAGES-1];

  logic [WORD_W-2:0] sr_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [WORD_W-1:0] word;
  logic [ADDR_W-1:0] w_addr, a_addr;
  logic [DATA_W-1:0] w_data;
  logic              word_done, addr_done;

  assign word      = {sr_q, bit_in};
  assign w_addr    = word[WORD_W-1 -: ADDR_W];
  assign w_data    = word[DATA_W-1:0];
  assign a_addr    = {sr_q[ADDR_W-2:0], bit_in};
  assign word_done = rise && (cnt_q == CNT_W'(WORD_W-1));
  assign addr_done = rise && (cnt_q == CNT_W'(ADDR_W-1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q  <= '0;
      cnt_q <= '0;
    end else if (!cs_on) begin
      sr_q  <= '0;
      cnt_q <= '0;
    end else if (rise) begin
      sr_q  <= word[WORD_W-2:0];
      cnt_q <= word_done ? '0 : cnt_q + 1'b1;
    end
  end

  function automatic logic in_range(input logic [ADDR_W-1:0] a);
    return 32'(a) < NUM_REGS;
  endfunction

  logic [DATA_W-1:0] regs [NUM_REGS];
  logic              readout, wr_ok, srst;

  assign readout = regs[RDOUT_ADDR][RDOUT_BIT];
  assign wr_ok   = word_done && in_range(w_addr) &&
                   (!readout || w_addr == ADDR_W'(RDOUT_ADDR));
  assign srst    = wr_ok && (w_addr == ADDR_W'(SRST_ADDR)) && w_data[SRST_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_REGS; i++) regs[i] <= '0;
    end else if (srst) begin
      for (int i = 0; i < NUM_REGS; i++) regs[i] <= '0;
    end else if (wr_ok) begin
      regs[w_addr[IDX_W-1:0]] <= w_data;
    end
  end

  logic [DATA_W-1:0] rd_q, rd_val;
  assign rd_val = (in_range(a_addr) && a_addr != ADDR_W'(RDOUT_ADDR))
                  ? regs[a_addr[IDX_W-1:0]] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      rd_q <= '0;
    else if (addr_done)
      rd_q <= rd_val;
    else if (fall && cnt_q >= CNT_W'(ADDR_W+1))
      rd_q <= {rd_q[DATA_W-2:0], 1'b0};
  end

  assign sdo_oe = readout;
  assign sdo    = readout & rd_q[DATA_W-1];

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_out
    assign cfg_q[g*DATA_W +: DATA_W] = regs[g];
  end
endmodule

// File: rtl/cfg_serial_port_chk.sv
module cfg_serial_port_chk #(
  parameter int DATA_W      = 16,
  parameter int NUM_REGS    = 16,
  parameter int SYNC_STAGES = 2,
  parameter int SRST_ADDR   = 0,
  parameter int SRST_BIT    = 7,
  parameter int RDOUT_ADDR  = 1,
  parameter int RDOUT_BIT   = 0
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       cs_n,
  input logic                       sclk,
  input logic                       sdo,
  input logic                       sdo_oe,
  input logic [NUM_REGS*DATA_W-1:0] cfg_q
);
  localparam int SETTLE = SYNC_STAGES + 3;
  localparam int CW     = $clog2(SETTLE + 1);
  localparam int TOT    = NUM_REGS * DATA_W;
  localparam logic [TOT-1:0] ONE_REG = {{(TOT-DATA_W){1'b0}}, {DATA_W{1'b1}}};
  localparam logic [TOT-1:0] KEEP    = ~(ONE_REG << (RDOUT_ADDR*DATA_W));

  logic [CW-1:0] cs_hi, sclk_hi;
  logic          ro;
  assign ro = cfg_q[RDOUT_ADDR*DATA_W + RDOUT_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_hi   <= '0;
      sclk_hi <= '0;
    end else begin
      if (!cs_n) cs_hi <= '0;
      else if (cs_hi != CW'(SETTLE)) cs_hi <= cs_hi + 1'b1;
      if (!sclk) sclk_hi <= '0;
      else if (sclk_hi != CW'(SETTLE)) sclk_hi <= sclk_hi + 1'b1;
    end
  end

  p_reset_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (cfg_q == '0 && !sdo_oe));

  p_idle_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_hi == CW'(SETTLE)) |=> ($stable(cfg_q) && $stable(sdo_oe)));

  p_selfclear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_q[SRST_ADDR*DATA_W + SRST_BIT]);

  p_readout_blocks_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ro && $past(ro)) |-> ((cfg_q & KEEP) == ($past(cfg_q) & KEEP)));

  p_sdo_steady_high_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk_hi == CW'(SETTLE)) |=> $stable(sdo));
endmodule

bind cfg_serial_port cfg_serial_port_chk #(
  .DATA_W(DATA_W), .NUM_REGS(NUM_REGS), .SYNC_STAGES(SYNC_STAGES),
  .SRST_ADDR(SRST_ADDR), .SRST_BIT(SRST_BIT),
  .RDOUT_ADDR(RDOUT_ADDR), .RDOUT_BIT(RDOUT_BIT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk),
  .sdo(sdo), .sdo_oe(sdo_oe), .cfg_q(cfg_q)
);

// File: tb/cfg_serial_port_tb.sv
module cfg_serial_port_tb;
  localparam int CLK_P = 10;
  localparam int HALF  = 8 * CLK_P;
  localparam int NREGS = 16;

  logic clk = 0, rst_n = 0, cs_n = 1, sclk = 0, sdi = 0;
  logic sdo, sdo_oe;
  logic [NREGS*16-1:0] cfg_q;

  int checks = 0, fails = 0;
  logic [15:0] m_regs [NREGS];
  logic        m_ro = 0;

  typedef struct { bit chk; logic [15:0] exp; string tag; } sb_item_t;
  sb_item_t sb_q[$];
  sb_item_t it;

  always #(CLK_P/2) clk = ~clk;

  cfg_serial_port #(.NUM_REGS(NREGS)) u_dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sdi(sdi),
    .sdo(sdo), .sdo_oe(sdo_oe), .cfg_q(cfg_q)
  );

  task automatic check_eq(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] reg_of(int i);
    return cfg_q[i*16 +: 16];
  endfunction

  function automatic logic [15:0] m_read(int a);
    return (a == 1 || a >= NREGS) ? 16'h0 : m_regs[a];
  endfunction

  function automatic void m_write(int a, logic [15:0] d);
    if (a >= NREGS) return;
    if (m_ro && a != 1) return;
    if (a == 0 && d[7]) for (int i = 0; i < NREGS; i++) m_regs[i] = '0;
    else m_regs[a] = d;
    m_ro = m_regs[1][0];
  endfunction

  task automatic check_regs(string req);
    for (int i = 0; i < NREGS; i++)
      check_eq(req, $sformatf("register %0d", i), 32'(reg_of(i)), 32'(m_regs[i]));
  endtask

  // monitor: collects readback bits and compares against the scoreboard
  int          mon_bit = 0;
  logic [15:0] mon_cap = '0;
  bit          mon_oe  = 1;
  always @(posedge sclk) if (!cs_n) begin
    mon_bit++;
    if (mon_bit > 8) begin
      mon_cap = {mon_cap[14:0], sdo};
      mon_oe  = mon_oe & sdo_oe;
    end else mon_oe = 1;
    if (mon_bit == 24) begin
      mon_bit = 0;
      if (sb_q.size() == 0) check_eq("R7", "scoreboard underflow", 0, 1);
      else begin
        it = sb_q.pop_front();
        if (it.chk) begin
          check_eq(it.tag, "readback data", 32'(mon_cap), 32'(it.exp));
          check_eq("R8", "sdo_oe during readback", 32'(mon_oe), 1);
        end
      end
    end
  end
  always @(posedge cs_n) mon_bit = 0;

  task automatic wait_clk(int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic bit_out(logic b);
    sdi = b; #(HALF); sclk = 1; #(HALF); sclk = 0;
  endtask

  task automatic bits_out(logic [31:0] v, int n);
    for (int i = n-1; i >= 0; i--) bit_out(v[i]);
  endtask

  task automatic frame_open();
    cs_n = 0; #(HALF);
  endtask

  task automatic frame_close();
    #(HALF); cs_n = 1; #(4*HALF);
  endtask

  task automatic word_out(int a, logic [15:0] d, string tag);
    logic [23:0] w;
    w = {8'(a), d};
    sb_q.push_back('{m_ro, m_read(a), tag});
    bits_out(32'(w), 24);
    m_write(a, d);
  endtask

  initial begin
    #(CLK_P * 190000);
    checks++; fails++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < NREGS; i++) m_regs[i] = '0;
    #(3*CLK_P);
    check_eq("R6", "cfg_q in reset", 32'(cfg_q == '0), 1);
    check_eq("R6", "sdo_oe in reset", 32'(sdo_oe), 0);
    rst_n = 1;
    wait_clk(2);
    check_regs("R6");
    check_eq("R8", "sdo_oe after reset", 32'(sdo_oe), 0);

    // R2 single word
    frame_open(); word_out(3, 16'hA5C3, "R2"); frame_close();
    check_eq("R2", "register 3", 32'(reg_of(3)), 32'h0000A5C3);

    // R3 several words per frame
    frame_open();
    word_out(4, 16'h1357, "R3"); word_out(5, 16'h8001, "R3"); word_out(6, 16'hFFFE, "R3");
    frame_close();
    check_regs("R3");

    // R1 sclk with chip-select high
    cs_n = 1;
    bits_out(32'h02FFFF, 24);
    #(2*HALF);
    check_regs("R1");

    // R4 trailing bits then a fresh frame
    frame_open(); word_out(7, 16'h1234, "R4"); bits_out(32'h08FFF, 20); frame_close();
    frame_open(); word_out(9, 16'hBEEF, "R4"); frame_close();
    check_regs("R4");
    // R4 aborted word
    frame_open(); bits_out(32'hFFF, 12); frame_close();
    frame_open(); word_out(10, 16'h0F0F, "R4"); frame_close();
    check_regs("R4");

    // R11 out-of-range writes (0x20 would alias register 0 and soft-reset)
    frame_open(); word_out(8'h20, 16'hFFFF, "R11"); word_out(8'h83, 16'h5555, "R11"); frame_close();
    check_regs("R11");

    // R5 plain write to register 0, then software reset, then a write in the same frame
    frame_open(); word_out(0, 16'h0041, "R5"); frame_close();
    check_eq("R5", "register 0 plain", 32'(reg_of(0)), 32'h41);
    frame_open(); word_out(0, 16'h00C0, "R5"); frame_close();
    check_regs("R5");
    frame_open(); word_out(0, 16'h0080, "R5"); word_out(2, 16'h7777, "R5"); frame_close();
    check_regs("R5");

    frame_open();
    word_out(3, 16'h9C31, "R2"); word_out(4, 16'h0F1E, "R2"); word_out(12, 16'h8001, "R2");
    frame_close();

    // R8 readout on
    frame_open(); word_out(1, 16'h0001, "R8"); frame_close();
    check_eq("R8", "sdo_oe in readout", 32'(sdo_oe), 1);

    // R7 reads, several per frame
    frame_open(); word_out(3, 0, "R7"); word_out(4, 0, "R7"); word_out(12, 0, "R7"); frame_close();

    // R10 register 0x01 reads as zero
    frame_open(); word_out(1, 16'h0001, "R10"); frame_close();

    // R9 writes blocked, soft reset blocked
    frame_open(); word_out(3, 16'h1111, "R9"); word_out(0, 16'h0080, "R9"); word_out(3, 0, "R9"); frame_close();
    check_regs("R9");

    // R11 out-of-range read
    frame_open(); word_out(8'h23, 0, "R11"); frame_close();

    // leave readout mode
    frame_open(); word_out(1, 16'h0000, "R8"); frame_close();
    check_eq("R8", "sdo_oe after exit", 32'(sdo_oe), 0);
    check_eq("R8", "sdo quiet after exit", 32'(sdo), 0);
    frame_open(); word_out(3, 16'h2222, "R9"); frame_close();
    check_eq("R9", "write after exit", 32'(reg_of(3)), 32'h2222);

    // R6 hardware reset from readout mode
    frame_open(); word_out(1, 16'h0001, "R6"); frame_close();
    check_eq("R8", "sdo_oe before hw reset", 32'(sdo_oe), 1);
    rst_n = 0;
    #(2*CLK_P);
    check_eq("R6", "cfg_q under hw reset", 32'(cfg_q == '0), 1);
    check_eq("R6", "sdo_oe under hw reset", 32'(sdo_oe), 0);
    for (int i = 0; i < NREGS; i++) m_regs[i] = '0;
    m_ro = 0;
    rst_n = 1;
    wait_clk(2);
    check_regs("R6");

    check_eq("R7", "scoreboard drained", sb_q.size(), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule